// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that software can read and load. It counts either instruction-cycle ticks or edges on an external pin that is already synchronized to the system clock. A single power-of-two prescaler sits in front of the counter. A control bit can hand that prescaler to the watchdog path instead. In that case the counter sees every source event, and the watchdog receives a divided version of its raw tick.

When the count rolls over from its top value to zero, a sticky overflow flag is set. An enable input masks the interrupt request made from that flag. While the sleep input is high, timer events are discarded. Any load of the count register discards the next two instruction ticks and restarts the prescaler.

Top module: `tmr_shared_prescale`

## Requirements
- R1: With control bit 5 = 0 (internal source) and bit 3 = 1 (prescaler on watchdog), the count rises by one on each clock where `cyc_tick` is high.
- R2: With control bit 5 = 1 (external source), the count moves on edges of `ext_clk` and ignores `cyc_tick`. Control bit 4 = 0 selects rising edges and 1 selects falling edges.
- R3: With control bit 3 = 0, the prescaler serves the timer. The count then rises once per 2^(r+1) source events, where r is control bits 2:0.
- R4: With control bit 3 = 1, `wdog_tick` pulses once per 2^r pulses of `wdt_raw`, one clock after the pulse that completes the group.
- R5: A `cnt_wr` pulse loads `cnt_wdata` into the count on the next clock. The next two `cyc_tick` pulses after it cause no counting.
- R6: A count load, or a control write that flips bit 3, returns the prescaler to zero.
- R7: An increment from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until a `flag_clr` pulse. A set in the same cycle as a clear takes priority.
- R8: `irq` is high exactly when `ovf_flag` and `ovf_ie` are both high.
- R9: While `sleep` is high, the count holds and no overflow can be raised.
- R10: After reset the count is 0, `ovf_flag`, `irq` and `wdog_tick` are 0, and the control register is 6'b111111.
- R11: With control bit 3 = 0, `wdog_tick` repeats `wdt_raw` one clock later, without division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-clock pulse per instruction cycle |
| ext_clk | input | 1 | Synchronized external count pin |
| wdt_raw | input | 1 | Undivided watchdog tick |
| sleep | input | 1 | Halts the timer |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wdata | input | 8 | Value to load |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | {src_ext, edge_fall, to_wdog, rate[2:0]} |
| ovf_ie | input | 1 | Overflow interrupt enable |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |
| wdog_tick | output | 1 | Tick offered to the watchdog |

## Verification
The assertions assume that `ext_clk` is already synchronous and that `cnt_wr` and `ctl_wr` are one-clock strobes. The hold-off property also assumes that a load is never issued in the same clock as `cyc_tick`. The stimulus drives every input at the falling clock edge. Each strobe lasts one clock, and loads fall only on clocks with no instruction tick. External edges are spaced by at least one clock, so each edge is detected exactly once.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int RATE_W = 3;
  localparam int PRE_W  = 2 ** RATE_W;
  localparam int CTL_W  = RATE_W + 3;

  typedef struct packed {
    logic              src_ext;
    logic              edge_fall;
    logic              to_wdog;
    logic [RATE_W-1:0] rate;
  } tmr_ctl_t;

  // Mask of prescaler bits that must all be set for a carry.
  function automatic logic [PRE_W-1:0] pre_mask(input logic to_wdog,
                                                 input logic [RATE_W-1:0] rate);
    int unsigned sh;
    sh = to_wdog ? int'(rate) : int'(rate) + 1;
    return PRE_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/tmr_event_src.sv
`timescale 1ns/1ps
module tmr_event_src (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic ext_clk,
  input  logic src_ext,
  input  logic edge_fall,
  output logic raw_evt
);
  logic ext_q;
  logic rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_clk;
  end

  assign rise_w  = ext_clk & ~ext_q;
  assign fall_w  = ~ext_clk & ext_q;
  assign raw_evt = src_ext ? (edge_fall ? fall_w : rise_w) : cyc_tick;

  // R2: an external edge event implies the pin moved since the last clock
  assert_ext_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && raw_evt) |-> (ext_clk != ext_q));
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [PRE_W-1:0] mask,
  output logic             carry
);
  logic [PRE_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (evt) pcnt <= pcnt + PRE_W'(1);
  end

  assign carry = evt && !clr && ((pcnt & mask) == mask);

  // R3: a carry leaves the selected low bits at zero (group restarts)
  assert_group_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> ((pcnt & $past(mask)) == '0));
  // R6: a clear leaves the prescaler empty
  assert_pre_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/tmr_wr_guard.sv
`timescale 1ns/1ps
module tmr_wr_guard #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic cnt_wr,
  output logic hold
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       left_q <= '0;
    else if (cnt_wr)                  left_q <= HW'(HOLD_CYC);
    else if (cyc_tick && left_q != 0) left_q <= left_q - HW'(1);
  end

  assign hold = (left_q != '0);

  // R5: the hold-off only wears away on instruction ticks
  assert_hold_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cyc_tick && !cnt_wr) |=> hold);
  // R5: a load always opens a hold-off window
  assert_hold_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> hold);
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] count,
  output logic              ovf_flag
);
  logic wrap_w;

  assign wrap_w = inc && !wr && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr)       count <= wdata;
      else if (inc) count <= count + DATA_W'(1);
      ovf_flag <= wrap_w | (ovf_flag & ~flag_clr);
    end
  end

  // R5: a load is visible one clock later
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (count == $past(wdata)));
  // R7: rollover raises the flag
  assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && count == '1) |=> (ovf_flag && count == '0));
  // R7: flag is sticky without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);
endmodule

// File: rtl/tmr_shared_prescale.sv
`timescale 1ns/1ps
module tmr_shared_prescale
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              ext_clk,
  input  logic              wdt_raw,
  input  logic              sleep,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] cnt_wdata,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ovf_ie,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] count,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wdog_tick
);
  tmr_ctl_t         ctl_q, ctl_new;
  logic             assign_flip;
  logic             pre_clr;
  logic             raw_evt;
  logic             hold;
  logic             tmr_evt;
  logic             pre_in;
  logic             pre_carry;
  logic             cnt_inc;
  logic [PRE_W-1:0] pre_sel_mask;

  assign ctl_new = tmr_ctl_t'(ctl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= tmr_ctl_t'({CTL_W{1'b1}});
    else if (ctl_wr) ctl_q <= ctl_new;
  end

  assign assign_flip  = ctl_wr && (ctl_new.to_wdog != ctl_q.to_wdog);
  assign pre_clr      = cnt_wr || assign_flip;
  assign pre_sel_mask = pre_mask(ctl_q.to_wdog, ctl_q.rate);

  tmr_event_src u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .ext_clk   (ext_clk),
    .src_ext   (ctl_q.src_ext),
    .edge_fall (ctl_q.edge_fall),
    .raw_evt   (raw_evt)
  );

  tmr_wr_guard #(.HOLD_CYC(HOLD_CYC)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_tick (cyc_tick),
    .cnt_wr   (cnt_wr),
    .hold     (hold)
  );

  assign tmr_evt = raw_evt && !sleep && !hold;
  assign pre_in  = ctl_q.to_wdog ? wdt_raw : tmr_evt;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pre_clr),
    .evt   (pre_in),
    .mask  (pre_sel_mask),
    .carry (pre_carry)
  );

  assign cnt_inc = ctl_q.to_wdog ? tmr_evt : pre_carry;

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cnt_inc),
    .wr       (cnt_wr),
    .wdata    (cnt_wdata),
    .flag_clr (flag_clr),
    .count    (count),
    .ovf_flag (ovf_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_tick <= 1'b0;
    else        wdog_tick <= ctl_q.to_wdog ? pre_carry : wdt_raw;
  end

  assign irq = ovf_flag & ovf_ie;

  // R9: sleep freezes the count
  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !cnt_wr) |=> (count == $past(count)));
  // R1: without a load the count holds or steps by one
  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) || count == $past(count) + DATA_W'(1)));
  // R5: the clock after a load leaves the count unchanged
  assert_post_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr) && !cnt_wr) |=> (count == $past(count)));
  // R11: without the prescaler the watchdog tick carries no division
  assert_wdog_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.to_wdog && !ctl_wr) |=> (wdog_tick == $past(wdt_raw)));
endmodule

// File: tb/tmr_shared_prescale_tb.sv
`timescale 1ns/1ps
module tmr_shared_prescale_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0, ext_clk = 1'b0, wdt_raw = 1'b0, sleep = 1'b0;
  logic       cnt_wr = 1'b0, ctl_wr = 1'b0, ovf_ie = 1'b0, flag_clr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [5:0] ctl_wdata = '0;
  logic [7:0] count;
  logic       ovf_flag, irq, wdog_tick;

  int checks = 0;
  int errors = 0;
  logic seen;
  int   tally;

  always #4 clk = ~clk;

  tmr_shared_prescale dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_clk(ext_clk),
    .wdt_raw(wdt_raw), .sleep(sleep), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ovf_ie(ovf_ie), .flag_clr(flag_clr),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .wdog_tick(wdog_tick)
  );

  // {ctl[5:0], tick count[15:0], expected count[7:0]}
  localparam int NVEC = 8;
  localparam logic [29:0] VEC [NVEC] = '{
    {6'b001000, 16'd10,  8'd8},
    {6'b000000, 16'd12,  8'd5},
    {6'b000001, 16'd20,  8'd4},
    {6'b000010, 16'd34,  8'd4},
    {6'b000111, 16'd600, 8'd2},
    {6'b001111, 16'd5,   8'd3},
    {6'b000011, 16'd2,   8'd0},
    {6'b000000, 16'd3,   8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) cyc_tick = 1'b1;
    @(negedge clk) cyc_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk) begin cnt_wr = 1'b1; cnt_wdata = v; end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    @(negedge clk) begin ctl_wr = 1'b1; ctl_wdata = v; end
    @(negedge clk) ctl_wr = 1'b0;
  endtask

  task automatic ext_set(input logic v);
    @(negedge clk) ext_clk = v;
    @(negedge clk);
  endtask

  task automatic wraw_pulse(output logic got);
    @(negedge clk) wdt_raw = 1'b1;
    @(negedge clk) begin wdt_raw = 1'b0; got = wdog_tick; end
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 count", count, 0);
    check("R10 flag", ovf_flag, 0);
    check("R10 irq", irq, 0);
    check("R10 wdog", wdog_tick, 0);
    // R10/R2: reset control selects external falling edge, 1:1 timer
    ext_set(1'b1);
    check("R2 rise ignored in falling mode", count, 0);
    ext_set(1'b0);
    check("R10 R2 falling edge counts", count, 1);
    // R10/R4: watchdog division 128 from reset control
    tally = 0;
    for (int i = 0; i < 127; i++) begin wraw_pulse(seen); tally += seen; end
    check("R4 no wdog tick before 128", tally, 0);
    wraw_pulse(seen);
    check("R4 wdog tick on 128th", seen, 1);

    // R1 R3: table of source/prescaler settings
    for (int v = 0; v < NVEC; v++) begin
      wr_ctl(VEC[v][29:24]);
      wr_cnt(8'h00);
      for (int t = 0; t < int'(VEC[v][23:8]); t++) tick();
      check(VEC[v][27] ? "R1 table direct" : "R3 table prescaled",
            count, int'(VEC[v][7:0]));
    end

    // R2: rising edges, instruction ticks ignored
    wr_ctl(6'b101000);
    wr_cnt(8'h00);
    tick(); tick(); tick();
    check("R2 ticks ignored with external source", count, 0);
    for (int i = 0; i < 3; i++) begin ext_set(1'b1); ext_set(1'b0); end
    check("R2 rising edges counted", count, 3);

    // R5: hold-off after a load
    wr_ctl(6'b001000);
    wr_cnt(8'h10);
    check("R5 load value", count, 16);
    tick();
    check("R5 first tick suppressed", count, 16);
    tick();
    check("R5 second tick suppressed", count, 16);
    tick();
    check("R5 third tick counts", count, 17);

    // R6: assignment flip clears prescaler (div 2)
    wr_ctl(6'b000000);
    wr_cnt(8'h00);
    tick(); tick(); tick();
    wr_ctl(6'b001000);
    wr_ctl(6'b000000);
    tick();
    check("R6 flip cleared prescaler", count, 0);
    tick();
    check("R6 count after restart", count, 1);
    // R6: load clears prescaler (div 4)
    wr_ctl(6'b000001);
    wr_cnt(8'h00);
    tick(); tick(); tick(); tick(); tick();
    wr_cnt(8'h05);
    tick(); tick(); tick();
    check("R6 load cleared prescaler", count, 5);
    tick(); tick(); tick();
    check("R6 group of four after load", count, 6);

    // R7 R8: overflow
    wr_ctl(6'b001000);
    wr_cnt(8'hFE);
    tick(); tick(); tick();
    check("R7 at FF", count, 255);
    check("R7 no flag before wrap", ovf_flag, 0);
    tick();
    check("R7 wrapped", count, 0);
    check("R7 flag set", ovf_flag, 1);
    check("R8 masked irq", irq, 0);
    @(negedge clk) ovf_ie = 1'b1;
    @(negedge clk);
    check("R8 enabled irq", irq, 1);
    tick(); tick();
    check("R7 flag sticky", ovf_flag, 1);
    pulse_clr();
    check("R7 flag cleared", ovf_flag, 0);
    check("R8 irq drops", irq, 0);

    // R9: sleep
    @(negedge clk) sleep = 1'b1;
    wr_cnt(8'hFF);
    for (int i = 0; i < 5; i++) tick();
    check("R9 count frozen", count, 255);
    check("R9 no overflow asleep", ovf_flag, 0);
    @(negedge clk) sleep = 1'b0;
    tick();
    check("R9 resumes after sleep", count, 0);
    check("R7 flag after resume", ovf_flag, 1);
    pulse_clr();

    // R11: pass-through with prescaler on timer
    wr_ctl(6'b000000);
    tally = 0;
    for (int i = 0; i < 3; i++) begin wraw_pulse(seen); tally += seen; end
    check("R11 undivided wdog", tally, 3);
    // R4: division by 4 on watchdog (rate 2)
    wr_ctl(6'b001010);
    tally = 0;
    for (int i = 0; i < 3; i++) begin wraw_pulse(seen); tally += seen; end
    check("R4 none before 4th", tally, 0);
    wraw_pulse(seen);
    check("R4 tick on 4th", seen, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule